// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a 36-bit-wide synchronous SRAM with a fixed two-stage pipeline. A command is taken from the address and control inputs on one rising edge. The data for that command moves on the bus two edges later, and this holds for both reads and writes. Because both kinds of operation have the same latency, a controller can alternate reads and writes on every cycle without an idle bus cycle between them.

The data bus is modelled as three separate ports: an input, an output and a drive enable. Storage is split into four 9-bit lanes, and each lane has its own write select. A command can also continue as a burst of four consecutive accesses from one loaded address. The burst address generator is a separate module, and a parameter selects either a linear or an interleaved order.

There are three further controls:
- A global clock enable freezes the whole pipeline.
- Three chip enables gate the start of new commands.
- A sleep input blocks new commands and silences the outputs.

Output enable acts on the bus asynchronously.

Top module: `zbt_sram`

## Requirements
- R1: A read command captured on edge k (`load_n`=0, chips selected, `write_n`=1) presents the stored word on `dq_out` with `dq_oe`=1 after edge k+1, so the word is valid when sampled on edge k+2.
- R2: A write command captured on edge k (`write_n`=0) stores `dq_in` as sampled on edge k+2. Only lane i, which is bits [9i+8:9i], is updated, and only when `byte_we_n[i]` was 0 on edge k.
- R3: Reads and writes may be issued on consecutive edges in any mix. A read issued on the edge right after a write to the same address returns the newly written lanes.
- R4: While `clk_en_n`=1, every synchronous input is ignored, no pipeline, output or memory state changes, and the pipeline resumes where it stopped once `clk_en_n` returns to 0.
- R5: A new command starts only when `cs_a_n`=0, `cs_b`=1 and `cs_c_n`=0 on a load edge (`load_n`=0). Any other combination starts no operation.
- R6: Operations already accepted into the pipeline complete even if the following edges carry a deselect.
- R7: `dq_oe` is 0 in the cycle after an edge that carried no read into the output stage, which covers a deselect or a write captured two edges earlier.
- R8: `out_en_n`=1 forces `dq_oe` to 0 at once, without waiting for a clock edge. The pending read data is kept and reappears when `out_en_n` returns to 0.
- R9: While `sleep`=1, commands (load or advance) are ignored, `dq_oe` is 0, and the memory contents are kept.
- R10: On an advance edge (`load_n`=1), the operation type of the previous command continues at the next address of a 4-word burst. The linear default keeps the address bits above bit 1 and steps the two low bits as start+1, start+2, start+3, wrapping modulo 4. Byte selects are sampled again on each advance edge. An advance that follows a no-operation edge is itself a no-operation.
- R11: After reset there is no pending operation and `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of control registers |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the block |
| cs_a_n | input | 1 | Chip enable, active low |
| cs_b | input | 1 | Chip enable, active high |
| cs_c_n | input | 1 | Chip enable, active low |
| write_n | input | 1 | Operation select: 1 read, 0 write |
| load_n | input | 1 | 0 loads a new address and command, 1 advances the burst |
| byte_we_n | input | 4 | Active-low write select per 9-bit lane |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Blocks new commands and silences outputs |
| addr | input | 6 | Word address |
| dq_in | input | 36 | Write data from the bus |
| dq_out | output | 36 | Read data to the bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The hardest situation to reach is a read that enters the output stage on the same edge as the pending write to the same address commits. On that edge the stored word is stale and the new lanes exist only on `dq_in`. The stimulus creates this case by issuing a write and a read to the same address on adjacent edges, first with all lanes and then after a clock-enable stall that holds both operations mid-pipeline. A scoreboard compares the bus against a model that applies each commit before the next fetch. This ordering catches a missing or lane-blind bypass.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } op_e;

   function automatic logic chips_on(input logic a_n, input logic b, input logic c_n);
      return !a_n && b && !c_n;
   endfunction

endpackage

// File: rtl/zbt_burst_addr.sv
module zbt_burst_addr #(
   parameter int ADDR_W      = 6,
   parameter bit INTERLEAVED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_en,
   input  logic              load,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_out
);
   localparam int OFS_W = 2;
   localparam int HI_W  = ADDR_W - OFS_W;

   if (ADDR_W <= OFS_W) begin : g_bad_width
      $error("zbt_burst_addr: ADDR_W must exceed burst offset width");
   end

   logic [HI_W-1:0]  hi_q;
   logic [OFS_W-1:0] lo_q, cnt_q, cnt_nx, lo_nx;

   assign cnt_nx = cnt_q + 1'b1;

   if (INTERLEAVED) begin : g_ileave
      assign lo_nx = lo_q ^ cnt_nx;
   end else begin : g_linear
      assign lo_nx = lo_q + cnt_nx;
   end

   assign addr_out = load ? addr_in : {hi_q, lo_nx};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q  <= '0;
         lo_q  <= '0;
         cnt_q <= '0;
      end else if (step_en) begin
         if (load) begin
            hi_q  <= addr_in[ADDR_W-1:OFS_W];
            lo_q  <= addr_in[OFS_W-1:0];
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_nx;
         end
      end
   end

   // R10
   burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !load) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/zbt_cmd_pipe.sv
module zbt_cmd_pipe
   import zbt_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce,
   input  logic              load_n,
   input  logic              write_n,
   input  logic              cs_a_n,
   input  logic              cs_b,
   input  logic              cs_c_n,
   input  logic              sleep,
   input  logic [LANES-1:0]  byte_we_n,
   input  logic [ADDR_W-1:0] addr_in,
   output op_e               op1,
   output logic [ADDR_W-1:0] addr1,
   output op_e               op2,
   output logic [ADDR_W-1:0] addr2,
   output logic [LANES-1:0]  be2
);
   logic             sel;
   op_e              op_nx;
   logic [LANES-1:0] be1;

   assign sel = chips_on(cs_a_n, cs_b, cs_c_n) && !sleep;

   always_comb begin
      if (!load_n) begin
         if (sel) op_nx = write_n ? OP_READ : OP_WRITE;
         else     op_nx = OP_IDLE;
      end else begin
         op_nx = sleep ? OP_IDLE : op1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op1   <= OP_IDLE;
         op2   <= OP_IDLE;
         addr1 <= '0;
         addr2 <= '0;
         be1   <= '0;
         be2   <= '0;
      end else if (ce) begin
         op1   <= op_nx;
         addr1 <= addr_in;
         be1   <= ~byte_we_n;
         op2   <= op1;
         addr2 <= addr1;
         be2   <= be1;
      end
   end

   // R5
   deselect_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && !load_n && !chips_on(cs_a_n, cs_b, cs_c_n)) |=> (op1 == OP_IDLE));

   // R9
   sleep_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && sleep) |=> (op1 == OP_IDLE));

   // R6
   pending_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && op1 != OP_IDLE) |=> (op2 == $past(op1)));

endmodule

// File: rtl/zbt_lane_array.sv
module zbt_lane_array #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    we,
   input  logic [ADDR_W-1:0]       waddr,
   input  logic [LANES-1:0]        wbe,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic [ADDR_W-1:0]       raddr,
   output logic [LANES*LANE_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] store [DEPTH];

      always_ff @(posedge clk) begin
         if (we && wbe[g]) store[waddr] <= wdata[g*LANE_W +: LANE_W];
      end

      assign rdata[g*LANE_W +: LANE_W] = store[raddr];
   end

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
   import zbt_pkg::*;
#(
   parameter int ADDR_W            = 6,
   parameter int LANES             = 4,
   parameter int LANE_W            = 9,
   parameter bit BURST_INTERLEAVED = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clk_en_n,
   input  logic                    cs_a_n,
   input  logic                    cs_b,
   input  logic                    cs_c_n,
   input  logic                    write_n,
   input  logic                    load_n,
   input  logic [LANES-1:0]        byte_we_n,
   input  logic                    out_en_n,
   input  logic                    sleep,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] dq_in,
   output logic [LANES*LANE_W-1:0] dq_out,
   output logic                    dq_oe
);
   localparam int DATA_W = LANES * LANE_W;

   if (LANES < 1 || LANE_W < 1) begin : g_bad_lanes
      $error("zbt_sram: lane count and width must be positive");
   end

   logic              ce;
   logic [ADDR_W-1:0] cmd_addr, addr1, addr2;
   op_e               op1, op2;
   logic [LANES-1:0]  be2;
   logic [DATA_W-1:0] mem_rd, merged, rd_data_q;
   logic              rd_drive_q, fwd_hit, commit;

   assign ce = !clk_en_n;

   zbt_burst_addr #(.ADDR_W(ADDR_W), .INTERLEAVED(BURST_INTERLEAVED)) u_burst (
      .clk(clk), .rst_n(rst_n), .step_en(ce), .load(!load_n),
      .addr_in(addr), .addr_out(cmd_addr)
   );

   zbt_cmd_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pipe (
      .clk(clk), .rst_n(rst_n), .ce(ce), .load_n(load_n), .write_n(write_n),
      .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n), .sleep(sleep),
      .byte_we_n(byte_we_n), .addr_in(cmd_addr),
      .op1(op1), .addr1(addr1), .op2(op2), .addr2(addr2), .be2(be2)
   );

   assign commit = ce && (op2 == OP_WRITE);

   zbt_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
      .clk(clk), .we(commit), .waddr(addr2), .wbe(be2), .wdata(dq_in),
      .raddr(addr1), .rdata(mem_rd)
   );

   assign fwd_hit = (op2 == OP_WRITE) && (addr2 == addr1);

   for (genvar g = 0; g < LANES; g++) begin : g_fwd
      assign merged[g*LANE_W +: LANE_W] = (fwd_hit && be2[g]) ?
         dq_in[g*LANE_W +: LANE_W] : mem_rd[g*LANE_W +: LANE_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_drive_q <= 1'b0;
         rd_data_q  <= '0;
      end else if (ce) begin
         rd_drive_q <= (op1 == OP_READ);
         if (op1 == OP_READ) rd_data_q <= merged;
      end
   end

   assign dq_out = rd_data_q;
   assign dq_oe  = rd_drive_q && !out_en_n && !sleep;

   // R7
   bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && op1 != OP_READ) |=> !rd_drive_q);

   // R4
   freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ce |=> ($stable(rd_drive_q) && $stable(rd_data_q)));

   // R3
   write_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && op1 == OP_READ && op2 == OP_WRITE && addr1 == addr2 && be2 == '1)
      |=> (rd_data_q == $past(dq_in)));

endmodule

// File: tb/zbt_sram_test.sv
module zbt_sram_test;
   localparam int AW = 6;
   localparam int LN = 4;
   localparam int LW = 9;
   localparam int DW = LN * LW;
   localparam logic [2:0] CS_ON  = 3'b010;
   localparam logic [2:0] CS_OFF = 3'b110;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          clk_en_n, cs_a_n, cs_b, cs_c_n, write_n, load_n;
   logic [LN-1:0] byte_we_n;
   logic          out_en_n, sleep;
   logic [AW-1:0] addr;
   logic [DW-1:0] dq_in, dq_out;
   logic          dq_oe;

   zbt_sram uut (
      .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .cs_a_n(cs_a_n), .cs_b(cs_b),
      .cs_c_n(cs_c_n), .write_n(write_n), .load_n(load_n), .byte_we_n(byte_we_n),
      .out_en_n(out_en_n), .sleep(sleep), .addr(addr), .dq_in(dq_in),
      .dq_out(dq_out), .dq_oe(dq_oe)
   );

   always #5 clk = ~clk;

   typedef struct {
      int            slot;
      bit            drv;
      logic [DW-1:0] dat;
      string         tag;
   } exp_t;

   exp_t  sb[$];
   string cur_tag = "R11";
   int    cyc = 0;
   int    checks = 0;
   int    errors = 0;
   bit    done = 0;

   // reference model state
   logic [DW-1:0] mmem [64];
   int            m_op1 = 0, m_op2 = 0;
   logic [AW-1:0] m_a1 = '0, m_a2 = '0;
   logic [LN-1:0] m_b1 = '0, m_b2 = '0;
   bit            m_drv = 0;
   logic [DW-1:0] m_dat = '0;
   logic [3:0]    b_hi = '0;
   logic [1:0]    b_lo = '0, b_cnt = '0;

   function automatic logic [DW-1:0] pat(input int c);
      logic [31:0] h;
      h = c * 32'h9E3779B1;
      return {h[3:0] ^ 4'hA, h};
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic step(input bit cen_n, input bit ld_n, input bit wn, input logic [2:0] cs,
                       input logic [LN-1:0] bwn, input logic [AW-1:0] a,
                       input bit oen, input bit slp);
      int            nop;
      logic [AW-1:0] na;
      logic [1:0]    lo_s;
      bit            sel;
      @(negedge clk);
      cyc++;
      clk_en_n = cen_n; load_n = ld_n; write_n = wn;
      {cs_a_n, cs_b, cs_c_n} = cs;
      byte_we_n = bwn; addr = a; out_en_n = oen; sleep = slp;
      dq_in = pat(cyc);
      if (!cen_n) begin
         if (m_op2 == 2)
            for (int i = 0; i < LN; i++)
               if (m_b2[i]) mmem[m_a2][i*LW +: LW] = dq_in[i*LW +: LW];
         if (m_op1 == 1) m_dat = mmem[m_a1];
         m_drv = (m_op1 == 1);
         sel = (cs == CS_ON) && !slp;
         if (!ld_n) begin
            nop = sel ? (wn ? 1 : 2) : 0;
            na = a; b_hi = a[5:2]; b_lo = a[1:0]; b_cnt = 2'd0;
         end else begin
            b_cnt = b_cnt + 2'd1;
            lo_s = b_lo + b_cnt;
            na = {b_hi, lo_s};
            nop = slp ? 0 : m_op1;
         end
         m_op2 = m_op1; m_a2 = m_a1; m_b2 = m_b1;
         m_op1 = nop; m_a1 = na; m_b1 = ~bwn;
      end
      sb.push_back('{cyc + 1, m_drv, m_dat, cur_tag});
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [LN-1:0] bwn);
      step(0, 0, 0, CS_ON, bwn, a, 0, 0);
   endtask
   task automatic rd(input logic [AW-1:0] a);
      step(0, 0, 1, CS_ON, '1, a, 0, 0);
   endtask
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 1, CS_OFF, '1, '0, 0, 0);
   endtask
   task automatic adv(input logic [LN-1:0] bwn);
      step(0, 1, 1, CS_OFF, bwn, '0, 0, 0);
   endtask

   // monitor: pops expectations as the design produces results
   initial begin
      exp_t e;
      bit   exp_oe;
      forever begin
         @(negedge clk);
         #2;
         if (sb.size() > 0 && sb[0].slot == cyc) begin
            e = sb.pop_front();
            exp_oe = e.drv && !out_en_n && !sleep;
            chk(dq_oe == exp_oe, e.tag, "dq_oe", {35'd0, dq_oe}, {35'd0, exp_oe});
            if (exp_oe) chk(dq_out == e.dat, e.tag, "dq_out", dq_out, e.dat);
         end
      end
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 64; i++) mmem[i] = '0;
      rst_n = 0; clk_en_n = 0; load_n = 0; write_n = 1;
      {cs_a_n, cs_b, cs_c_n} = CS_OFF;
      byte_we_n = '1; out_en_n = 0; sleep = 0; addr = '0; dq_in = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R11: reset state leaves the bus undriven
      chk(dq_oe == 1'b0, "R11", "dq_oe in reset", {35'd0, dq_oe}, '0);
      rst_n = 1;
      idle(1);
      chk(dq_oe == 1'b0, "R11", "dq_oe after reset", {35'd0, dq_oe}, '0);

      cur_tag = "R2";
      for (int a = 0; a < 64; a++) wr(a[AW-1:0], '0);
      idle(2);
      cur_tag = "R1";
      for (int a = 0; a < 64; a++) rd(a[AW-1:0]);
      idle(3);

      cur_tag = "R2";   // lanes 0 and 2 only
      wr(6'd3, 4'b1010);
      idle(2);
      rd(6'd3);
      idle(3);

      cur_tag = "R3";
      for (int i = 0; i < 8; i++) begin
         wr(6'(8 + i % 4), '0);
         rd(6'(8 + i % 4));
         rd(6'(8 + (i + 1) % 4));
      end
      wr(6'd11, 4'b0110);
      rd(6'd11);
      idle(3);

      cur_tag = "R4";
      rd(6'd5);
      for (int i = 0; i < 3; i++) step(1, 0, 0, CS_ON, '0, 6'd5, 0, 0);
      idle(2);
      rd(6'd5);
      wr(6'd9, '0);
      step(1, 0, 1, CS_ON, '1, 6'd9, 0, 0);
      step(1, 0, 0, CS_ON, '0, 6'd2, 0, 0);
      rd(6'd9);
      idle(3);

      cur_tag = "R5";
      step(0, 0, 0, 3'b110, '0, 6'd1, 0, 0);
      step(0, 0, 0, 3'b000, '0, 6'd1, 0, 0);
      step(0, 0, 0, 3'b011, '0, 6'd1, 0, 0);
      step(0, 0, 1, 3'b000, '1, 6'd1, 0, 0);
      idle(2);
      rd(6'd1);
      idle(3);

      cur_tag = "R6";
      rd(6'd7);
      idle(3);

      cur_tag = "R7";
      rd(6'd2);
      wr(6'd4, '0);
      rd(6'd2);
      idle(3);

      cur_tag = "R8";
      rd(6'd6);
      idle(1);
      step(0, 0, 1, CS_OFF, '1, '0, 1, 0);
      idle(3);

      cur_tag = "R9";
      step(0, 0, 0, CS_ON, '0, 6'd12, 0, 1);
      rd(6'd13);
      idle(1);
      step(0, 0, 1, CS_OFF, '1, '0, 0, 1);
      idle(1);
      rd(6'd12);
      idle(3);

      cur_tag = "R10";
      wr(6'd6, '0);
      adv('0);
      adv(4'b1110);
      adv('0);
      idle(2);
      rd(6'd6);
      adv('1);
      adv('1);
      adv('1);
      idle(2);
      rd(6'd7);
      idle(2);
      adv('1);
      adv('1);
      idle(3);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule